// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block drives the frequency control word of a fractional synthesizer so that the synthesized clock follows a linear triangular frequency sweep around a programmed nominal value. Spreading the clock energy over a band lowers the peak emission at the fundamental and its harmonics. The block has two sweep modes. In center mode the word swings equally above and below nominal. In down mode it swings only below nominal. The sweep depth is a 5-bit code in quarter-percent steps.

A free-running prescaler gives an update tick every `DIV` clocks. On every tick the block presents a new word with a one-cycle strobe. The half-period of the triangle is `2^L` ticks, where `L` is the period setting, so a full modulation period is `2^(L+1)` ticks. With the defaults (`DIV` = 50, `L` = 5, 100 MHz clock) the modulation rate is 31.25 kHz.

An active-low enable turns the sweep on. While the enable is inactive, the word sits at exactly nominal. Configuration is taken only while spread is off or at the start of a modulation period, so a sweep in progress never jumps.

Top module: `ssm_profile_gen`

## Requirements
- R1: In center mode (mode input 0) with clamped code k, the deviation is dev = floor(nom·k/400). The word reaches a trough of nom−dev and a peak of nom+dev within each period.
- R2: In down mode (mode input 1), the word sweeps between nom and nom−dev and never exceeds nom.
- R3: The code is clamped to 1..10 in center mode and to 2..20 in down mode. The period setting L is clamped to 1..MAX_L.
- R4: An update tick occurs every DIV clocks and sets the strobe for exactly one cycle. The word changes only together with the strobe. A modulation period lasts 2·2^L ticks, with the trough at tick index 2^(L−1) (center) or 2^L (down) after the period start.
- R5: At period tick index i, the phase is p = (p0+i) mod 2^(L+1), where p0 = 2^(L−1) in center mode and 0 in down mode. With tri = p if p < 2^L, else 2^(L+1)−p, the word is top − floor(span·tri/2^L). Here top = nom+dev and span = 2·dev in center mode, and top = nom and span = dev in down mode. The ramps are therefore monotonic.
- R6: At every tick on which the enable input is high (spread off), the word equals the nominal input. This includes the first tick after the enable is raised.
- R7: The first tick after the enable goes low outputs exactly nominal, and the sweep then moves below nominal first.
- R8: Changes to nominal, mode, code or period setting made while a sweep is running have no effect until the next period start. From that point the new configuration applies.
- R9: During reset the word is 0 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| nom_word_i | input | WORD_W | Nominal frequency control word |
| spread_mode_i | input | 1 | 0 = center sweep, 1 = down sweep |
| spread_code_i | input | 5 | Sweep depth in 0.25 % units |
| period_log_i | input | PER_W | Log2 of half-period length in ticks |
| spread_en_ni | input | 1 | 0 = sweep on, 1 = hold nominal |
| word_o | output | WORD_W | Instantaneous control word |
| word_stb_o | output | 1 | One-cycle pulse marking each new word |

## Verification
The bench goes after the quarter-phase start of the center sweep. A design that started the triangle at an extreme would output a peak or trough instead of nominal on the first enabled tick, and would put the trough at the wrong index. It checks the exact endpoints. A span or shift off by one would miss nom±dev by a step, and a wrong down-mode top would cross above nominal. Illegal codes and a zero period setting are applied to catch missing clamps, which would give a flat or oversized sweep or a 1-tick period. A mid-period configuration change is applied to expose a design that takes new settings at once and so jumps in the middle of a ramp.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    localparam int CODE_W     = 5;
    localparam int PCT_DEN    = 400;
    localparam int CTR_K_MIN  = 1;
    localparam int CTR_K_MAX  = 10;
    localparam int DN_K_MIN   = 2;
    localparam int DN_K_MAX   = 20;

    typedef enum logic {
        SWEEP_CENTER = 1'b0,
        SWEEP_DOWN   = 1'b1
    } sweep_mode_e;
endpackage

// File: rtl/ssm_tick_gen.sv
module ssm_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q + CNT_W'(1);
        tick_o = (cnt_q == LAST);
        if (tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/ssm_cfg_clamp.sv
module ssm_cfg_clamp
    import ssm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PER_W  = 4,
    parameter int MAX_L  = 10,
    parameter int LOG_W  = 4
) (
    input  logic [WORD_W-1:0] nom_i,
    input  logic              down_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PER_W-1:0]  period_i,
    output logic [WORD_W-1:0] dev_o,
    output logic [LOG_W-1:0]  lg_o
);
    localparam int PROD_W = WORD_W + CODE_W;

    logic [CODE_W-1:0] k_min, k_max, k_use;
    logic [PROD_W-1:0] prod, quot;

    always_comb begin
        k_min = down_i ? CODE_W'(DN_K_MIN) : CODE_W'(CTR_K_MIN);
        k_max = down_i ? CODE_W'(DN_K_MAX) : CODE_W'(CTR_K_MAX);
        if (code_i < k_min) begin
            k_use = k_min;
        end else if (code_i > k_max) begin
            k_use = k_max;
        end else begin
            k_use = code_i;
        end
        prod  = PROD_W'(nom_i) * PROD_W'(k_use);
        quot  = prod / PROD_W'(PCT_DEN);
        dev_o = quot[WORD_W-1:0];
    end

    always_comb begin
        if (period_i == '0) begin
            lg_o = LOG_W'(1);
        end else if (32'(period_i) > MAX_L) begin
            lg_o = LOG_W'(MAX_L);
        end else begin
            lg_o = LOG_W'(period_i);
        end
    end
endmodule

// File: rtl/ssm_wave_calc.sv
module ssm_wave_calc #(
    parameter int WORD_W = 32,
    parameter int MAX_L  = 10,
    parameter int LOG_W  = 4,
    parameter int PH_W   = 11
) (
    input  logic [WORD_W-1:0] nom_i,
    input  logic [WORD_W-1:0] dev_i,
    input  logic              down_i,
    input  logic [LOG_W-1:0]  lg_i,
    input  logic [PH_W-1:0]   ph_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int EXT_W  = WORD_W + 1;
    localparam int MUL_W  = EXT_W + PH_W;

    logic [PH_W:0]    half, tri_v;
    logic [EXT_W-1:0] top, span, res;
    logic [MUL_W-1:0] prod, scaled;

    always_comb begin
        half  = (PH_W+1)'(1) << lg_i;
        if ({1'b0, ph_i} < half) begin
            tri_v = {1'b0, ph_i};
        end else begin
            tri_v = (half << 1) - {1'b0, ph_i};
        end
        if (down_i) begin
            top  = EXT_W'(nom_i);
            span = EXT_W'(dev_i);
        end else begin
            top  = EXT_W'(nom_i) + EXT_W'(dev_i);
            span = EXT_W'(dev_i) << 1;
        end
        prod   = MUL_W'(span) * MUL_W'(tri_v);
        scaled = prod >> lg_i;
        res    = top - scaled[EXT_W-1:0];
        word_o = res[WORD_W-1:0];
    end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PER_W  = 4,
    parameter int MAX_L  = 10,
    parameter int DIV    = 50
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] nom_word_i,
    input  logic              spread_mode_i,
    input  logic [4:0]        spread_code_i,
    input  logic [PER_W-1:0]  period_log_i,
    input  logic              spread_en_ni,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o
);
    localparam int LOG_W = $clog2(MAX_L + 1);
    localparam int PH_W  = MAX_L + 1;

    typedef struct packed {
        logic [WORD_W-1:0] nom;
        logic [WORD_W-1:0] dev;
        logic              down;
        logic [LOG_W-1:0]  lg;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic [PH_W-1:0]   ph;
        logic              start;
        logic [WORD_W-1:0] word;
        logic              stb;
    } state_t;

    state_t st_d, st_q;
    cfg_t   cfg_new;
    logic   tick;
    logic [WORD_W-1:0] dev_new, wave_word;
    logic [LOG_W-1:0]  lg_new;
    logic [PH_W-1:0]   ph_next;

    function automatic logic [PH_W-1:0] start_phase(input logic down, input logic [LOG_W-1:0] lg);
        logic [PH_W:0] half;
        half = (PH_W+1)'(1) << lg;
        return down ? '0 : half[PH_W:1];
    endfunction

    function automatic logic [PH_W-1:0] wrap_mask(input logic [LOG_W-1:0] lg);
        logic [PH_W+1:0] full;
        full = ((PH_W+2)'(1) << (lg + LOG_W'(1))) - (PH_W+2)'(1);
        return full[PH_W-1:0];
    endfunction

    ssm_tick_gen #(.DIV(DIV)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    ssm_cfg_clamp #(
        .WORD_W (WORD_W),
        .PER_W  (PER_W),
        .MAX_L  (MAX_L),
        .LOG_W  (LOG_W)
    ) clamp_i (
        .nom_i    (nom_word_i),
        .down_i   (spread_mode_i),
        .code_i   (spread_code_i),
        .period_i (period_log_i),
        .dev_o    (dev_new),
        .lg_o     (lg_new)
    );

    ssm_wave_calc #(
        .WORD_W (WORD_W),
        .MAX_L  (MAX_L),
        .LOG_W  (LOG_W),
        .PH_W   (PH_W)
    ) wave_i (
        .nom_i  (st_q.cfg.nom),
        .dev_i  (st_q.cfg.dev),
        .down_i (st_q.cfg.down),
        .lg_i   (st_q.cfg.lg),
        .ph_i   (st_q.ph),
        .word_o (wave_word)
    );

    always_comb begin
        cfg_new.nom  = nom_word_i;
        cfg_new.dev  = dev_new;
        cfg_new.down = (spread_mode_i == SWEEP_DOWN);
        cfg_new.lg   = lg_new;

        ph_next = (st_q.ph + PH_W'(1)) & wrap_mask(st_q.cfg.lg);

        st_d     = st_q;
        st_d.stb = 1'b0;
        if (tick) begin
            st_d.stb = 1'b1;
            if (spread_en_ni) begin
                st_d.cfg   = cfg_new;
                st_d.word  = nom_word_i;
                st_d.start = 1'b1;
            end else if (st_q.start) begin
                st_d.cfg   = cfg_new;
                st_d.word  = nom_word_i;
                st_d.ph    = (start_phase(cfg_new.down, cfg_new.lg) + PH_W'(1))
                             & wrap_mask(cfg_new.lg);
                st_d.start = 1'b0;
            end else begin
                st_d.word  = wave_word;
                st_d.ph    = ph_next;
                st_d.start = (ph_next == start_phase(st_q.cfg.down, st_q.cfg.lg));
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o     = st_q.word;
    assign word_stb_o = st_q.stb;
endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              spread_en_ni,
    input logic [WORD_W-1:0] nom_word_i,
    input logic [WORD_W-1:0] word_o,
    input logic              word_stb_o,
    input logic              cfg_down_q,
    input logic [WORD_W-1:0] cfg_nom_q
);
    // R6: a tick taken with spread off presents the nominal input
    a_r6_off_is_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_stb_o && $past(spread_en_ni)) |-> (word_o == $past(nom_word_i)));

    // R2: down sweep never rises above the captured nominal
    a_r2_down_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_stb_o && cfg_down_q) |-> (word_o <= cfg_nom_q));

    // R4: strobe lasts a single cycle
    a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_stb_o |=> !word_stb_o);

    // R4: word only moves together with the strobe
    a_r4_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_stb_o |-> $stable(word_o));
endmodule

bind ssm_profile_gen ssm_profile_chk #(.WORD_W(WORD_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spread_en_ni (spread_en_ni),
    .nom_word_i   (nom_word_i),
    .word_o       (word_o),
    .word_stb_o   (word_stb_o),
    .cfg_down_q   (st_q.cfg.down),
    .cfg_nom_q    (st_q.cfg.nom)
);

// File: tb/ssm_profile_gen_tb_top.sv
module ssm_profile_gen_tb_top;
    localparam int DIV_TB = 4;
    localparam int WW     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] nom_i = '0;
    logic          mode_i = 1'b0;
    logic [4:0]    code_i = '0;
    logic [3:0]    per_i = '0;
    logic          en_n = 1'b1;
    logic [WW-1:0] word;
    logic          stb;

    int  tests = 0;
    int  fails = 0;
    int  cyc = 0;
    int  last_stb = 0;
    bit  done = 1'b0;

    // fields: [41] mode, [40:36] code, [35:32] period setting, [31:0] nominal
    localparam logic [41:0] VECS [8] = '{
        {1'b0, 5'd4,  4'd3, 32'd100000000},
        {1'b0, 5'd10, 4'd4, 32'h3000_0000},
        {1'b0, 5'd0,  4'd2, 32'd50000000},
        {1'b0, 5'd25, 4'd3, 32'd150000000},
        {1'b1, 5'd20, 4'd3, 32'd100000000},
        {1'b1, 5'd1,  4'd4, 32'd80000000},
        {1'b1, 5'd31, 4'd0, 32'd120000000},
        {1'b1, 5'd8,  4'd5, 32'd123456789}
    };

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ssm_profile_gen #(.WORD_W(WW), .PER_W(4), .MAX_L(10), .DIV(DIV_TB)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .nom_word_i    (nom_i),
        .spread_mode_i (mode_i),
        .spread_code_i (code_i),
        .period_log_i  (per_i),
        .spread_en_ni  (en_n),
        .word_o        (word),
        .word_stb_o    (stb)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_k(input bit md, input int code);
        int lo = md ? 2 : 1;
        int hi = md ? 20 : 10;
        return (code < lo) ? lo : ((code > hi) ? hi : code);
    endfunction

    function automatic int clamp_l(input int lp);
        return (lp < 1) ? 1 : ((lp > 10) ? 10 : lp);
    endfunction

    function automatic longint model(input bit md, input int kc, input int lc,
                                     input longint nom, input int idx);
        longint h   = longint'(1) << lc;
        longint dev = (nom * kc) / 400;
        longint p   = ((md ? 0 : h / 2) + idx) % (2 * h);
        longint tr  = (p < h) ? p : (2 * h - p);
        longint top = md ? nom : nom + dev;
        longint spn = md ? dev : 2 * dev;
        return top - ((spn * tr) >> lc);
    endfunction

    task automatic wait_stb();
        do @(negedge clk); while (!stb);
        if (last_stb != 0) chk((cyc - last_stb) == DIV_TB, "R4 strobe spacing", cyc - last_stb, DIV_TB);
        last_stb = cyc;
    endtask

    task automatic run_vec(input bit md, input int code, input int lp, input longint nom);
        int     kc  = clamp_k(md, code);
        int     lc  = clamp_l(lp);
        int     h   = 1 << lc;
        longint dev = (nom * kc) / 400;
        longint act, e, eprev, prev, mn, mx;
        string  tag = (kc != code || lc != lp) ? " R3 clamp" : "";
        en_n = 1'b1; mode_i = md; code_i = 5'(code); per_i = 4'(lp); nom_i = 32'(nom);
        for (int r = 0; r < 2; r++) begin
            wait_stb();
            chk(longint'(word) == nom, "R6 disabled holds nominal", longint'(word), nom);
        end
        en_n = 1'b0;
        mn = nom; mx = nom; prev = 0; eprev = 0;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 2 * h; i++) begin
                wait_stb();
                act = longint'(word);
                e = model(md, kc, lc, nom, i);
                chk(act == e, {"R5 sweep point", tag}, act, e);
                if (p == 0 && i == 0) chk(act == nom, "R7 restart at nominal", act, nom);
                if (p == 0 && i == 1 && e < nom) chk(act < nom, "R7 heads lower first", act, nom);
                if (i > 0 && e < eprev) chk(act <= prev, "R5 monotonic fall", act, prev);
                if (i > 0 && e > eprev) chk(act >= prev, "R5 monotonic rise", act, prev);
                if (i == (md ? h : h / 2)) chk(act == nom - dev, "R4 trough tick index", act, nom - dev);
                if (act < mn) mn = act;
                if (act > mx) mx = act;
                prev = act; eprev = e;
            end
        end
        if (md) begin
            chk(mn == nom - dev, {"R2 down trough", tag}, mn, nom - dev);
            chk(mx == nom, "R2 down never above nominal", mx, nom);
        end else begin
            chk(mn == nom - dev, {"R1 center trough", tag}, mn, nom - dev);
            chk(mx == nom + dev, {"R1 center peak", tag}, mx, nom + dev);
        end
        en_n = 1'b1;
        wait_stb();
        chk(longint'(word) == nom, "R6 nominal on next tick after disable", longint'(word), nom);
    endtask

    task automatic run_midchange();
        longint n1 = 200000000;
        longint n2 = 300000000;
        longint act, e;
        en_n = 1'b1; mode_i = 1'b0; code_i = 5'd8; per_i = 4'd3; nom_i = 32'(n1);
        wait_stb();
        en_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            wait_stb();
            if (i == 3) begin
                nom_i = 32'(n2); mode_i = 1'b1; code_i = 5'd2; per_i = 4'd2;
            end
            act = longint'(word);
            e = model(1'b0, 8, 3, n1, i);
            chk(act == e, "R8 mid-period change ignored", act, e);
        end
        for (int i = 0; i < 8; i++) begin
            wait_stb();
            act = longint'(word);
            e = model(1'b1, 2, 2, n2, i);
            chk(act == e, "R8 new config at period start", act, e);
        end
        en_n = 1'b1;
        wait_stb();
        chk(longint'(word) == n2, "R6 nominal after disable", longint'(word), n2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(word == '0, "R9 reset word", longint'(word), 0);
        chk(stb == 1'b0, "R9 reset strobe", longint'(stb), 0);
        rst_n = 1'b1;
        for (int v = 0; v < 8; v++) begin
            run_vec(VECS[v][41], int'(VECS[v][40:36]), int'(VECS[v][35:32]), longint'(VECS[v][31:0]));
        end
        run_midchange();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule